// File: doc/BRIEF.md
# Page-Walk Access Permission Checker

This block decides whether a memory access is allowed by the page-level rights found during a multi-level address translation walk. A walker outside the block presents one paging-structure entry per cycle, starting at the top level and moving down to the final level. The block merges the writable and user-accessible flags of every level it sees. After the final entry it reports whether the access faults and, if it does, why.

With the first entry of a walk, the caller gives a two-bit privilege level, the access kind (read or write) and a write-protect control bit. Levels 0 to 2 run in supervisor mode and level 3 runs in user mode. One cycle after the final entry, the block raises `done` for one cycle. During that cycle `fault` and `fault_code` are valid.

The control path is a three-state machine. IDLE waits for a walk. WALK accumulates further entries. REPORT drives the one-cycle result. IDLE goes to WALK when a start entry is not final, and to REPORT when it is final. WALK stays in WALK while it takes non-final entries or sits idle. WALK goes to REPORT on a final entry, and a fresh start in WALK restarts the walk in place. REPORT goes back to IDLE. A start in REPORT opens a new walk and moves to WALK, or stays in REPORT if that start entry is also final.

Top module: `pwalk_perm_check`

## Requirements
- R1: In each entry, bit 1 is the writable flag and bit 2 is the user-accessible flag. The effective writable flag and the effective user flag are each the AND of that bit over every entry of the walk.
- R2: Privilege level 3 is user mode. A user-mode access faults with code 01 when any walked entry has its user flag at 0.
- R3: A write faults with code 10 when any walked entry has its writable flag at 0, if the access is in user mode or the write-protect bit is 1.
- R4: When both the R2 and R3 conditions hold, the code is 01.
- R5: Privilege levels 0, 1 and 2 are supervisor mode. They never produce code 01. A supervisor write with write-protect 0 and any read both give code 00 unless R2 or R3 applies.
- R6: `done` is high for exactly the one cycle after the cycle in which the final entry is presented. `fault` and `fault_code` are 0 whenever `done` is low. `fault` is 1 exactly when `fault_code` is not 00.
- R7: A walk ends at an entry with `entry_last` high, or at its LEVELS-th entry (default 4) even when `entry_last` is low.
- R8: A `walk_start` during a walk drops all earlier entries and starts a new walk with the presented entry as its first.
- R9: `priv_lvl`, `is_write` and `wp_en` are taken only with `walk_start`. Entries presented with no walk open are ignored and produce no `done`.
- R10: After reset, `done`, `fault` and `fault_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| walk_start | input | 1 | Presents the first entry of a new walk |
| entry_valid | input | 1 | Presents a further entry of the open walk |
| entry_last | input | 1 | The presented entry is the final level |
| entry | input | ENTRY_W | Paging-structure entry; bit 1 writable, bit 2 user |
| priv_lvl | input | 2 | Current privilege level, taken with walk_start |
| is_write | input | 1 | 1 for a write access, taken with walk_start |
| wp_en | input | 1 | Write-protect control, taken with walk_start |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Access faults; valid with done |
| fault_code | output | 2 | 00 none, 01 privilege, 10 read-only |

## Verification
Every result is due in the cycle after the edge that takes the final entry, because only the state register lies between that entry and `done`. The bench drives each entry at a falling edge and samples the outputs at the next falling edge after the final entry. One cycle later it confirms that `done` has dropped again. For the restart, stray-entry and depth-limit cases, `done` is also sampled in each cycle in between, so an early or missing strobe is seen in the cycle where it occurs.

// File: rtl/pwalk_pkg.sv
package pwalk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WALK   = 2'b01,
        ST_REPORT = 2'b10
    } walk_state_t;

    typedef enum logic [1:0] {
        FC_NONE   = 2'b00,
        FC_PRIV   = 2'b01,
        FC_RDONLY = 2'b10
    } fault_code_t;

    localparam int RW_BIT = 1;
    localparam int US_BIT = 2;

endpackage

// File: rtl/pwalk_flag_accum.sv
module pwalk_flag_accum (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    input  logic us_in,
    input  logic rw_in,
    output logic eff_us,
    output logic eff_rw
);

    // load: the accumulators restart at 1 and take this entry (R8)
    // step: AND this entry's flags into the running values (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_us <= 1'b1;
            eff_rw <= 1'b1;
        end else if (load) begin
            eff_us <= us_in;
            eff_rw <= rw_in;
        end else if (step) begin
            eff_us <= eff_us & us_in;
            eff_rw <= eff_rw & rw_in;
        end
    end

endmodule

// File: rtl/pwalk_decide.sv
module pwalk_decide
    import pwalk_pkg::*;
(
    input  logic        eff_us,
    input  logic        eff_rw,
    input  logic        user_mode,
    input  logic        wr_acc,
    input  logic        wp,
    output fault_code_t code,
    output logic        any_fault
);

    logic priv_viol;
    logic rdonly_viol;

    always_comb begin
        priv_viol   = user_mode && !eff_us;
        rdonly_viol = wr_acc && !eff_rw && (user_mode || wp);
        any_fault   = priv_viol || rdonly_viol;
        if (priv_viol)        code = FC_PRIV;     // R4 priority
        else if (rdonly_viol) code = FC_RDONLY;
        else                  code = FC_NONE;
    end

    // a_r4_priv_first: a privilege violation never reports as read-only
    always_comb begin
        a_r4_priv_first: assert (!(priv_viol && code != FC_PRIV));
    end

endmodule

// File: rtl/pwalk_perm_check.sv
module pwalk_perm_check
    import pwalk_pkg::*;
#(
    parameter int ENTRY_W = 64,
    parameter int LEVELS  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               walk_start,
    input  logic               entry_valid,
    input  logic               entry_last,
    input  logic [ENTRY_W-1:0] entry,
    input  logic [1:0]         priv_lvl,
    input  logic               is_write,
    input  logic               wp_en,
    output logic               done,
    output logic               fault,
    output logic [1:0]         fault_code
);

    localparam int CNT_W = $clog2(LEVELS + 1);

    walk_state_t      state, state_nx;
    logic [CNT_W-1:0] lvl_cnt, lvl_cnt_nx;
    logic             take_first, take_next, take, finish;
    logic             lat_user, lat_write, lat_wp;
    logic             eff_us, eff_rw;
    logic             dec_fault;
    fault_code_t      dec_code;
    logic             unused_entry_bits;

    assign unused_entry_bits = ^{entry[ENTRY_W-1:US_BIT+1], entry[0]};

    // Entry acceptance and depth tracking
    always_comb begin
        take_first = walk_start;
        take_next  = (state == ST_WALK) && entry_valid && !walk_start;
        take       = take_first || take_next;
        lvl_cnt_nx = take_first ? CNT_W'(1) : lvl_cnt + CNT_W'(1);
        finish     = take && (entry_last || lvl_cnt_nx == CNT_W'(LEVELS));
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = take_first ? (finish ? ST_REPORT : ST_WALK) : ST_IDLE;
            ST_WALK:   state_nx = (take && finish) ? ST_REPORT : ST_WALK;
            ST_REPORT: state_nx = take_first ? (finish ? ST_REPORT : ST_WALK) : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lvl_cnt   <= '0;
            lat_user  <= 1'b0;
            lat_write <= 1'b0;
            lat_wp    <= 1'b0;
        end else begin
            state <= state_nx;
            if (take) lvl_cnt <= lvl_cnt_nx;
            if (take_first) begin
                lat_user  <= (priv_lvl == 2'd3);
                lat_write <= is_write;
                lat_wp    <= wp_en;
            end
        end
    end

    pwalk_flag_accum u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take_first),
        .step   (take_next),
        .us_in  (entry[US_BIT]),
        .rw_in  (entry[RW_BIT]),
        .eff_us (eff_us),
        .eff_rw (eff_rw)
    );

    pwalk_decide u_decide (
        .eff_us    (eff_us),
        .eff_rw    (eff_rw),
        .user_mode (lat_user),
        .wr_acc    (lat_write),
        .wp        (lat_wp),
        .code      (dec_code),
        .any_fault (dec_fault)
    );

    // Outputs
    always_comb begin
        done       = (state == ST_REPORT);
        fault      = done && dec_fault;
        fault_code = done ? dec_code : FC_NONE;
    end

    // Assertions
    a_r6_done_after_start_last: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_start && entry_last) |=> done);

    a_r6_done_after_walk_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WALK && entry_valid && entry_last) |=> done);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !walk_start) |=> !done);

    a_r6_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!fault && fault_code == 2'b00));

    a_r6_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault == (fault_code != 2'b00)));

    a_r5_super_no_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !lat_user) |-> (fault_code != 2'b01));

    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_cnt <= CNT_W'(LEVELS));

    a_r9_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !walk_start) |=> !done);

endmodule

// File: tb/pwalk_perm_check_test.sv
module pwalk_perm_check_test;

    localparam int ENTRY_W = 64;
    localparam int LEVELS  = 4;
    localparam int NVEC    = 11;

    // vector: depth[16:14] us[13:10] rw[9:6] priv[5:4] wr[3] wp[2] exp[1:0]
    // us/rw bit i belongs to walk level i (0 = top)
    localparam logic [16:0] VEC [NVEC] = '{
        {3'd4, 4'b1111, 4'b1111, 2'd3, 1'b1, 1'b0, 2'b00},
        {3'd4, 4'b1101, 4'b1111, 2'd3, 1'b0, 1'b0, 2'b01},
        {3'd4, 4'b1111, 4'b1011, 2'd3, 1'b1, 1'b0, 2'b10},
        {3'd4, 4'b1111, 4'b1011, 2'd3, 1'b0, 1'b0, 2'b00},
        {3'd4, 4'b1111, 4'b0111, 2'd0, 1'b1, 1'b0, 2'b00},
        {3'd4, 4'b1111, 4'b0111, 2'd0, 1'b1, 1'b1, 2'b10},
        {3'd4, 4'b0000, 4'b0000, 2'd2, 1'b1, 1'b1, 2'b10},
        {3'd2, 4'b0001, 4'b0000, 2'd3, 1'b1, 1'b0, 2'b01},
        {3'd1, 4'b0001, 4'b0001, 2'd3, 1'b1, 1'b0, 2'b00},
        {3'd3, 4'b0111, 4'b0011, 2'd1, 1'b0, 1'b1, 2'b00},
        {3'd3, 4'b0111, 4'b0011, 2'd3, 1'b1, 1'b1, 2'b10}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               walk_start = 1'b0;
    logic               entry_valid = 1'b0;
    logic               entry_last = 1'b0;
    logic [ENTRY_W-1:0] entry = '0;
    logic [1:0]         priv_lvl = 2'd0;
    logic               is_write = 1'b0;
    logic               wp_en = 1'b0;
    logic               done;
    logic               fault;
    logic [1:0]         fault_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pwalk_perm_check #(.ENTRY_W(ENTRY_W), .LEVELS(LEVELS)) uut (
        .clk(clk), .rst_n(rst_n), .walk_start(walk_start),
        .entry_valid(entry_valid), .entry_last(entry_last), .entry(entry),
        .priv_lvl(priv_lvl), .is_write(is_write), .wp_en(wp_en),
        .done(done), .fault(fault), .fault_code(fault_code)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ENTRY_W-1:0] mk(input logic us, input logic rw);
        logic [ENTRY_W-1:0] e;
        e = {{(ENTRY_W-3){1'b1}}, 3'b001};
        e[2] = us;
        e[1] = rw;
        return e;
    endfunction

    task automatic idle_inputs();
        walk_start  = 1'b0;
        entry_valid = 1'b0;
        entry_last  = 1'b0;
        entry       = '0;
    endtask

    // Drive one walk; context is changed after the first entry (R9)
    task automatic run_walk(input int depth, input logic [3:0] us, input logic [3:0] rw,
                            input logic [1:0] pl, input logic wr, input logic wp,
                            input logic use_last);
        for (int i = 0; i < depth; i++) begin
            @(negedge clk);
            walk_start  = (i == 0);
            entry_valid = 1'b1;
            entry_last  = use_last && (i == depth - 1);
            entry       = mk(us[i], rw[i]);
            priv_lvl    = (i == 0) ? pl : ~pl;
            is_write    = (i == 0) ? wr : ~wr;
            wp_en       = (i == 0) ? wp : ~wp;
            if (i > 0) check(done == 1'b0, "R6 no early done", int'(done), 0);
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic expect_result(input logic [1:0] exp, input string req);
        check(done == 1'b1, {req, " done"}, int'(done), 1);
        check(fault_code == exp, {req, " code"}, int'(fault_code), int'(exp));
        check(fault == (exp != 2'b00), "R6 fault flag", int'(fault), int'(exp != 2'b00));
        @(negedge clk);
        check(done == 1'b0, "R6 single pulse", int'(done), 0);
        check(fault_code == 2'b00 && !fault, "R6 quiet outputs", int'(fault_code), 0);
    endtask

    initial begin
        fork
            begin
                while (cycles < 100000) @(posedge clk) cycles++;
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        // R10: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0 && fault == 1'b0 && fault_code == 2'b00, "R10 reset outputs",
              int'({done, fault, fault_code}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R10 idle after reset", int'(done), 0);

        // Table: R1 R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            run_walk(int'(VEC[v][16:14]), VEC[v][13:10], VEC[v][9:6], VEC[v][5:4],
                     VEC[v][3], VEC[v][2], 1'b1);
            expect_result(VEC[v][1:0], $sformatf("R1-table vector %0d", v));
        end

        // R7: walk closes at the LEVELS-th entry without entry_last
        run_walk(LEVELS, 4'b1111, 4'b1110, 2'd3, 1'b1, 1'b0, 1'b0);
        expect_result(2'b10, "R7 depth limit");

        // R8: restart mid-walk drops a supervisor-only entry
        @(negedge clk);
        walk_start = 1'b1; entry_valid = 1'b1; entry = mk(1'b0, 1'b0);
        priv_lvl = 2'd3; is_write = 1'b1; wp_en = 1'b1;
        @(negedge clk);
        walk_start = 1'b0; entry = mk(1'b0, 1'b1);
        check(done == 1'b0, "R8 no done mid-walk", int'(done), 0);
        run_walk(2, 4'b0011, 4'b0011, 2'd3, 1'b1, 1'b0, 1'b1);
        expect_result(2'b00, "R8 restart discards");

        // R9: stray entries with no open walk are ignored
        @(negedge clk);
        entry_valid = 1'b1; entry_last = 1'b1; entry = mk(1'b0, 1'b0);
        @(negedge clk);
        idle_inputs();
        check(done == 1'b0, "R9 stray entry no done", int'(done), 0);
        @(negedge clk);
        check(done == 1'b0, "R9 stray entry still idle", int'(done), 0);
        run_walk(1, 4'b0001, 4'b0001, 2'd3, 1'b1, 1'b1, 1'b1);
        expect_result(2'b00, "R9 stray entry left no trace");

        // R5: supervisor read of a supervisor-only read-only page
        run_walk(3, 4'b0000, 4'b0000, 2'd0, 1'b0, 1'b1, 1'b1);
        expect_result(2'b00, "R5 supervisor read");

        // R4: user write to a page failing both tests at one level
        run_walk(4, 4'b1011, 4'b1011, 2'd3, 1'b1, 1'b1, 1'b1);
        expect_result(2'b01, "R4 priority");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule